// File: doc/BRIEF.md
# Dual-Stage Operand Input Register with Cascade Tap

This block is the front end for one operand of an arithmetic datapath. A build-time parameter decides whether the operand is taken from the block's own direct data input or from a cascade input that a neighbouring instance drives. The chosen word then goes through zero, one or two register stages before it reaches the datapath output.

A second output feeds the cascade input of the next instance in a chain. It is tapped from its own stage of the same pipeline, and that stage may be shallower than the main output or equal to it. A tap depth of zero makes the cascade output a combinational copy of the selected input.

Each register stage has its own clock enable. One synchronous, active-high reset clears every stage, and reset wins over the enables. A tap depth larger than the main depth stops elaboration with an error.

Top module: `opnd_inreg`

## Requirements
- R1: With the source parameter set to direct, the selected operand follows `din_direct`, and changes on `din_casc` have no effect on either output.
- R2: With the source parameter set to cascade, the selected operand follows `din_casc`, and changes on `din_direct` have no effect on either output.
- R3: With a main depth of 0, `dout` equals the selected operand in the same cycle, with no clock edge needed.
- R4: With a main depth of 1, `dout` shows the selected operand that was present at the last rising edge where `en_s1` was high, and `en_s2` has no effect.
- R5: With a main depth of 2, stage 1 loads the selected operand on an edge where `en_s1` is high. Stage 2 loads the old stage 1 value on an edge where `en_s2` is high. `dout` is stage 2.
- R6: With a main depth of 2 and a tap depth of 1, `casc_out` is the stage 1 value, so `dout` lags `casc_out` by one enabled stage 2 load.
- R7: With a tap depth of 0, `casc_out` equals the selected operand combinationally.
- R8: A stage whose enable is low at an edge keeps its value, while the other stage still loads if its own enable is high.
- R9: When `rst` is high at a rising edge, every register stage becomes zero, whatever the enables are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset of all stages |
| en_s1 | input | 1 | Clock enable of register stage 1 |
| en_s2 | input | 1 | Clock enable of register stage 2 |
| din_direct | input | WIDTH | Operand from the block's own port |
| din_casc | input | WIDTH | Operand from a neighbouring instance's cascade output |
| dout | output | WIDTH | Operand to the datapath, after the main depth |
| casc_out | output | WIDTH | Operand to the next instance, after the tap depth |

## Verification
The bench builds three instances at the same time.

- **Main instance:** main depth 2, tap depth 1, cascade source. It covers the two-stage chain, the split between the tap and the main output, and every combination of the two enables.
- **Second instance:** main depth 1, tap depth 0, direct source. It covers the single register, the combinational tap, and the fact that the second enable does nothing there.
- **Third instance:** main depth 0, cascade source. It shows a pure wire path in which the unselected input is ignored.

All three share the stimulus, so reset priority over asserted enables is checked on every register at once.

// File: rtl/opnd_pipe_pkg.sv
package opnd_pipe_pkg;

    // Which input feeds the pipeline.
    typedef enum logic {
        SRC_DIRECT  = 1'b0,
        SRC_CASCADE = 1'b1
    } src_sel_e;

    // Deepest main pipeline supported.
    localparam int MAX_DEPTH = 2;

    // A configuration is legal when both depths are in range
    // and the cascade tap is no deeper than the main output.
    function automatic bit depth_ok(input int main_d, input int tap_d);
        return (main_d >= 0) && (main_d <= MAX_DEPTH) &&
               (tap_d >= 0) && (tap_d <= main_d);
    endfunction

endpackage

// File: rtl/opnd_src_mux.sv
module opnd_src_mux
    import opnd_pipe_pkg::*;
#(
    parameter int       WIDTH   = 25,
    parameter src_sel_e SRC_SEL = SRC_DIRECT
) (
    input  logic [WIDTH-1:0] din_direct,
    input  logic [WIDTH-1:0] din_casc,
    output logic [WIDTH-1:0] sel_out
);

    // The source is fixed at build time, so only one path is built.
    generate
        if (SRC_SEL == SRC_CASCADE) begin : g_casc
            assign sel_out = din_casc;
        end else begin : g_direct
            assign sel_out = din_direct;
        end
    endgenerate

endmodule

// File: rtl/opnd_stage_reg.sv
module opnd_stage_reg #(
    parameter int WIDTH = 25
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    // Reset is checked first, so it wins over the enable.
    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

    // Copy of reset from the previous edge, used by the reset check.
    logic rst_seen = 1'b0;
    always_ff @(posedge clk) rst_seen <= rst;

    p_reset_clears_r9: assert property (@(posedge clk)
        rst_seen |-> (q == '0));

    p_hold_when_off_r8: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(q));

    p_load_when_on_r5: assert property (@(posedge clk) disable iff (rst)
        en |=> (q == $past(d)));

endmodule

// File: rtl/opnd_inreg.sv
module opnd_inreg
    import opnd_pipe_pkg::*;
#(
    parameter int       WIDTH      = 25,
    parameter int       MAIN_DEPTH = 2,
    parameter int       TAP_DEPTH  = 1,
    parameter src_sel_e SRC_SEL    = SRC_DIRECT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en_s1,
    input  logic             en_s2,
    input  logic [WIDTH-1:0] din_direct,
    input  logic [WIDTH-1:0] din_casc,
    output logic [WIDTH-1:0] dout,
    output logic [WIDTH-1:0] casc_out
);

    // Stop elaboration on an illegal pair of depths.
    generate
        if (!depth_ok(MAIN_DEPTH, TAP_DEPTH)) begin : g_bad_depth
            $error("opnd_inreg: tap depth %0d vs main depth %0d is illegal",
                   TAP_DEPTH, MAIN_DEPTH);
        end
    endgenerate

    // Index 0 is the selected input; index k is the output of stage k.
    logic [WIDTH-1:0] tap_w [0:MAIN_DEPTH];

    opnd_src_mux #(
        .WIDTH   (WIDTH),
        .SRC_SEL (SRC_SEL)
    ) u_src (
        .din_direct (din_direct),
        .din_casc   (din_casc),
        .sel_out    (tap_w[0])
    );

    generate
        for (genvar k = 1; k <= MAIN_DEPTH; k++) begin : g_stage
            logic stage_en;
            assign stage_en = (k == 1) ? en_s1 : en_s2;

            opnd_stage_reg #(
                .WIDTH (WIDTH)
            ) u_reg (
                .clk (clk),
                .rst (rst),
                .en  (stage_en),
                .d   (tap_w[k-1]),
                .q   (tap_w[k])
            );
        end
    endgenerate

    assign dout     = tap_w[MAIN_DEPTH];
    assign casc_out = tap_w[TAP_DEPTH];

    // With two stages and a tap at stage 1, the main output follows the tap by one load.
    generate
        if (MAIN_DEPTH == 2 && TAP_DEPTH == 1) begin : g_chain_chk
            p_tap_leads_main_r6: assert property (@(posedge clk) disable iff (rst)
                en_s2 |=> (dout == $past(casc_out)));
        end
    endgenerate

endmodule

// File: tb/opnd_inreg_tb_top.sv
module opnd_inreg_tb_top;
    import opnd_pipe_pkg::*;

    localparam int  CLK_PERIOD = 10;
    localparam int  W          = 16;
    localparam int  NVEC       = 8;

    typedef struct packed {
        logic         en1;
        logic         en2;
        logic [W-1:0] dir;
        logic [W-1:0] cas;
        logic [W-1:0] m_dout;   // main instance: depth 2, tap 1, cascade source
        logic [W-1:0] m_tap;
        logic [W-1:0] s_dout;   // second instance: depth 1, tap 0, direct source
        logic [W-1:0] s_tap;
    } vec_t;

    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 16'h1111, 16'hA001, 16'h0000, 16'hA001, 16'h1111, 16'h1111},
        '{1'b1, 1'b1, 16'h2222, 16'hA002, 16'hA001, 16'hA002, 16'h2222, 16'h2222},
        '{1'b0, 1'b1, 16'h3333, 16'hA003, 16'hA002, 16'hA002, 16'h2222, 16'h3333},
        '{1'b1, 1'b0, 16'h4444, 16'hA004, 16'hA002, 16'hA004, 16'h4444, 16'h4444},
        '{1'b0, 1'b0, 16'h5555, 16'hA005, 16'hA002, 16'hA004, 16'h4444, 16'h5555},
        '{1'b1, 1'b1, 16'h6666, 16'hA006, 16'hA004, 16'hA006, 16'h6666, 16'h6666},
        '{1'b1, 1'b1, 16'h7777, 16'hFFFF, 16'hA006, 16'hFFFF, 16'h7777, 16'h7777},
        '{1'b1, 1'b1, 16'h0000, 16'h0000, 16'hFFFF, 16'h0000, 16'h0000, 16'h0000}
    };

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en_s1 = 1'b0;
    logic         en_s2 = 1'b0;
    logic [W-1:0] din_direct = '0;
    logic [W-1:0] din_casc = '0;
    logic [W-1:0] m_dout, m_tap, s_dout, s_tap, z_dout, z_tap;

    int  n_checks = 0;
    int  n_fails  = 0;
    bit  done     = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_inreg #(.WIDTH(W), .MAIN_DEPTH(2), .TAP_DEPTH(1), .SRC_SEL(SRC_CASCADE)) dut_i (
        .clk(clk), .rst(rst), .en_s1(en_s1), .en_s2(en_s2),
        .din_direct(din_direct), .din_casc(din_casc), .dout(m_dout), .casc_out(m_tap));

    opnd_inreg #(.WIDTH(W), .MAIN_DEPTH(1), .TAP_DEPTH(0), .SRC_SEL(SRC_DIRECT)) dut_s (
        .clk(clk), .rst(rst), .en_s1(en_s1), .en_s2(en_s2),
        .din_direct(din_direct), .din_casc(din_casc), .dout(s_dout), .casc_out(s_tap));

    opnd_inreg #(.WIDTH(W), .MAIN_DEPTH(0), .TAP_DEPTH(0), .SRC_SEL(SRC_CASCADE)) dut_z (
        .clk(clk), .rst(rst), .en_s1(en_s1), .en_s2(en_s2),
        .din_direct(din_direct), .din_casc(din_casc), .dout(z_dout), .casc_out(z_tap));

    task automatic check(input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Drive on the falling edge, then sample a quarter period after the rising edge.
    task automatic step();
        @(posedge clk);
        #(CLK_PERIOD/4);
    endtask

    initial begin
        // Reset state, R9
        @(negedge clk);
        rst = 1'b1; en_s1 = 1'b1; en_s2 = 1'b1;
        din_direct = 16'hBEEF; din_casc = 16'hCAFE;
        step();
        check("R9", "main dout after reset", m_dout, '0);
        check("R9", "main tap after reset", m_tap, '0);
        check("R9", "single dout after reset", s_dout, '0);
        step();
        check("R9", "main dout held in reset", m_dout, '0);

        @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < NVEC; i++) begin
            en_s1 = VEC[i].en1; en_s2 = VEC[i].en2;
            din_direct = VEC[i].dir; din_casc = VEC[i].cas;
            step();
            check("R5", $sformatf("main dout vec %0d", i), m_dout, VEC[i].m_dout);
            check("R6", $sformatf("main tap vec %0d", i), m_tap, VEC[i].m_tap);
            check("R4", $sformatf("single dout vec %0d", i), s_dout, VEC[i].s_dout);
            check("R7", $sformatf("single tap vec %0d", i), s_tap, VEC[i].s_tap);
            @(negedge clk);
        end

        // Depth 0 is combinational from the cascade input; the direct input is ignored (R3, R2).
        en_s1 = 1'b0; en_s2 = 1'b0;
        din_casc = 16'h1234; din_direct = 16'h9999;
        #1;
        check("R3", "zero-depth dout", z_dout, 16'h1234);
        check("R7", "zero-depth tap", z_tap, 16'h1234);
        din_direct = 16'h5A5A;
        #1;
        check("R2", "zero-depth ignores direct", z_dout, 16'h1234);

        // The direct-source instance ignores the cascade input (R1).
        din_direct = 16'h0F0F; din_casc = 16'h7E7E;
        #1;
        check("R1", "single tap follows direct", s_tap, 16'h0F0F);
        din_casc = 16'h1111;
        #1;
        check("R1", "single tap ignores cascade", s_tap, 16'h0F0F);

        // Load known values, then reset with both enables high (R9 priority).
        @(negedge clk);
        en_s1 = 1'b1; en_s2 = 1'b1; din_casc = 16'h4321; din_direct = 16'h8765;
        step();
        step();
        check("R5", "main dout before reset", m_dout, 16'h4321);
        @(negedge clk);
        rst = 1'b1; din_casc = 16'hAAAA; din_direct = 16'hBBBB;
        step();
        check("R9", "main dout reset wins", m_dout, '0);
        check("R9", "main tap reset wins", m_tap, '0);
        check("R9", "single dout reset wins", s_dout, '0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 2000);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

endmodule